// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value in a wide unpacked form and packs it into a 32-bit IEEE single-precision word. The value arrives as a class tag, a sign, an unbiased signed exponent, and a mantissa whose top bit is the explicit leading one. The bits below the 23-bit fraction act as guard, round and extra sticky bits, and a separate sticky input is ORed with them. The block rounds under one of four rounding directions. It handles the subnormal range with a saturating right shift. It propagates a rounding carry into the exponent. It replaces results that are too large with infinity or with the largest finite value, depending on the rounding direction and the sign.

A result appears one clock after a cycle with `inValid` high, together with four status flags: inexact, underflow, overflow and operand error. Between valid inputs the outputs hold their last value. The mantissa layout is: bit `MANT_W-1` is the leading one, bits `MANT_W-2` down to `MANT_W-24` are the fraction, and everything lower counts as discarded precision.

Top module: `sp_packer`

## Requirements
- R1: Class code 0 (zero) produces a word with only the input sign at bit 31 and all other bits zero, and no flag set.
- R2: Class code 2 (infinity) produces the sign, exponent field 0xFF and fraction zero, and no flag set.
- R3: Class code 3 (NaN) produces exponent 0xFF and a fraction made of the top 23 fraction bits of the input, with fraction bit 22 (the quiet bit) forced to 1. No flag is set.
- R4: For class code 1 (number), the biased exponent is the input exponent plus 127. When it lies in 1..254 after rounding, the word is sign at bit 31, biased exponent at bits 30:23 and rounded fraction at bits 22:0. Rounding direction codes are 0 nearest with ties to even, 1 toward zero, 2 toward minus infinity and 3 toward plus infinity.
- R5: For numbers, the inexact flag is set exactly when any discarded bit or the sticky input is nonzero, or when the result overflows.
- R6: When a normal mantissa rounds up to 2.0, the exponent field is one higher and the fraction is zero.
- R7: When the biased exponent is 0 or below, the underflow flag is set and the mantissa, leading one included, is shifted right by 1 minus the biased exponent. The result is then rounded and emitted with exponent field 0.
- R8: On that subnormal path, if rounding carries into the leading-one position, the output is exponent field 1 with a zero fraction, and the underflow flag is still set.
- R9: Any deficit large enough to move every mantissa bit below the guard position folds all bits into sticky. The result is then zero or the smallest subnormal, as the rounding direction decides, and inexact is set.
- R10: When the biased exponent after rounding is 255 or more, overflow, inexact and operand error are set. The word is infinity for direction 0, for direction 3 with a positive sign and for direction 2 with a negative sign. Otherwise it is exponent 0xFE with an all-ones fraction.
- R11: Word and flags appear the cycle after `inValid` is high, `outValid` is high in exactly that cycle, and word and flags hold while `inValid` is low.
- R12: During reset the word, the flags and `outValid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input value is present this cycle |
| inClass | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| inSign | input | 1 | Sign of the value |
| inExp | input | EXP_W | Unbiased exponent, two's complement |
| inMant | input | MANT_W | Mantissa, explicit leading one at the top bit |
| inSticky | input | 1 | OR of precision already lost upstream |
| rndMode | input | 2 | Rounding direction code |
| outValid | output | 1 | Packed word is new this cycle |
| outWord | output | 32 | Packed single-precision word |
| flagInexact | output | 1 | Result was rounded or replaced |
| flagUnderflow | output | 1 | Value took the subnormal path |
| flagOverflow | output | 1 | Exponent exceeded the finite range |
| flagOpErr | output | 1 | Operand error raised with overflow |

## Verification
The bench targets exact ties where only the fraction's low bit decides. A rounder that ignores it would bias every tie upward. It also drives all-ones mantissas that carry into the exponent. A design that drops that carry emits a fraction of zero under the old exponent, which halves the value. Subnormal inputs that round up into the smallest normal are covered too. A design that misses this case emits exponent 0, which reads as a value near zero. Deficits far beyond the mantissa width are driven as well, where a shifter that wraps instead of saturating would send live bits back into the word. Overflows are tried in every direction with both signs, because choosing the wrong replacement swaps infinity for the largest finite value.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

  localparam int FRAC_W  = 23;
  localparam int EFLD_W  = 8;
  localparam int BIAS    = 127;
  localparam int EXP_TOP = 255;
  localparam int KEEP_W  = FRAC_W + 3;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } valClass_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_DOWN = 2'd2,
    RND_UP   = 2'd3
  } rndMode_e;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_INF,
    SEL_NAN,
    SEL_MAXFIN,
    SEL_MINNORM,
    SEL_SUB,
    SEL_NORM
  } outSel_e;

  typedef struct packed {
    logic    load;
    outSel_e sel;
  } packStrobe_t;

  typedef struct packed {
    logic guardBit;
    logic roundBit;
    logic stickyBit;
    logic lsbBit;
    logic subPath;
  } preStat_t;

  typedef struct packed {
    logic minNorm;
    logic normCarry;
    logic expTooBig;
  } postStat_t;

endpackage

// File: rtl/sp_pack_dp.sv
module sp_pack_dp
  import sp_pack_pkg::*;
#(
  parameter int EXP_W  = 12,
  parameter int MANT_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  packStrobe_t             strb,
  input  logic                    rndUp,
  input  logic                    inValid,
  input  valClass_e               inClass,
  input  logic                    inSign,
  input  logic signed [EXP_W-1:0] inExp,
  input  logic [MANT_W-1:0]       inMant,
  input  logic                    inSticky,
  output preStat_t                preStat,
  output postStat_t               postStat,
  output logic [31:0]             outWord
);

  localparam int PRE_SH = MANT_W - KEEP_W;
  localparam int SH_MAX = KEEP_W + 1;
  localparam int SH_W   = $clog2(SH_MAX + 1);
  localparam int BEXP_W = EXP_W + 2;
  localparam int WIDE_W = KEEP_W + SH_MAX;
  localparam int SIG_W  = FRAC_W + 1;

  logic signed [BEXP_W-1:0] biasedExp;
  logic signed [BEXP_W-1:0] deficit;
  logic signed [BEXP_W-1:0] expNext;
  logic [SH_W-1:0]          shAmt;
  logic [KEEP_W-1:0]        kept;
  logic [KEEP_W-1:0]        keptSh;
  logic [WIDE_W-1:0]        wideVec;
  logic                     lowStk;
  logic                     lostBits;
  logic                     subPath;
  logic [SIG_W-1:0]         mSig;
  logic [SIG_W:0]           rounded;
  logic [31:0]              wordNext;

  // biased exponent in a width that cannot wrap
  assign biasedExp = $signed({{2{inExp[EXP_W-1]}}, inExp}) + BEXP_W'(BIAS);
  assign deficit   = BEXP_W'(1) - biasedExp;
  assign subPath   = (biasedExp <= 0);

  assign kept = inMant[MANT_W-1 -: KEEP_W];

  generate
    if (PRE_SH > 0) begin : g_lowFold
      assign lowStk = (|inMant[PRE_SH-1:0]) | inSticky;
    end else begin : g_noLow
      assign lowStk = inSticky;
    end
  endgenerate

  // saturating denormalising shift
  always_comb begin
    if (!subPath) begin
      shAmt = '0;
    end else if (deficit >= SH_MAX) begin
      shAmt = SH_W'(SH_MAX);
    end else begin
      shAmt = SH_W'(deficit);
    end
  end

  assign wideVec  = {kept, {SH_MAX{1'b0}}} >> shAmt;
  assign keptSh   = wideVec[WIDE_W-1 -: KEEP_W];
  assign lostBits = |wideVec[SH_MAX-1:0];
  assign mSig     = keptSh[KEEP_W-1:2];

  assign preStat.guardBit  = keptSh[1];
  assign preStat.roundBit  = keptSh[0];
  assign preStat.stickyBit = lostBits | lowStk;
  assign preStat.lsbBit    = mSig[0];
  assign preStat.subPath   = subPath;

  // increment stage
  assign rounded = {1'b0, mSig} + (SIG_W + 1)'(rndUp);
  assign expNext = biasedExp + BEXP_W'(rounded[SIG_W]);

  assign postStat.normCarry = rounded[SIG_W];
  assign postStat.minNorm   = subPath & rounded[FRAC_W];
  assign postStat.expTooBig = !subPath && (expNext >= EXP_TOP);

  always_comb begin
    unique case (strb.sel)
      SEL_ZERO:    wordNext = {inSign, 31'd0};
      SEL_INF:     wordNext = {inSign, {EFLD_W{1'b1}}, {FRAC_W{1'b0}}};
      SEL_NAN:     wordNext = {inSign, {EFLD_W{1'b1}}, 1'b1, inMant[MANT_W-3 -: FRAC_W-1]};
      SEL_MAXFIN:  wordNext = {inSign, EFLD_W'(EXP_TOP - 1), {FRAC_W{1'b1}}};
      SEL_MINNORM: wordNext = {inSign, EFLD_W'(1), {FRAC_W{1'b0}}};
      SEL_SUB:     wordNext = {inSign, {EFLD_W{1'b0}}, rounded[FRAC_W-1:0]};
      SEL_NORM:    wordNext = {inSign, expNext[EFLD_W-1:0], rounded[FRAC_W-1:0]};
      default:     wordNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outWord <= '0;
    end else if (strb.load) begin
      outWord <= wordNext;
    end
  end

  p_zero_mag_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inClass == CLS_ZERO |=> outWord[30:0] == 31'd0);

  p_nan_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inClass == CLS_NAN |=> outWord[30:22] == 9'h1FF);

  p_word_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outWord));

endmodule

// File: rtl/sp_pack_ctrl.sv
module sp_pack_ctrl
  import sp_pack_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  valClass_e   inClass,
  input  logic        inSign,
  input  rndMode_e    rndMode,
  input  preStat_t    preStat,
  input  postStat_t   postStat,
  output logic        rndUp,
  output packStrobe_t strb,
  output logic        outValid,
  output logic        flagInexact,
  output logic        flagUnderflow,
  output logic        flagOverflow,
  output logic        flagOpErr
);

  logic lossAny;
  logic toInf;
  logic isNum;
  logic ovfNow;

  assign lossAny = preStat.guardBit | preStat.roundBit | preStat.stickyBit;
  assign isNum   = (inClass == CLS_NUM);
  assign ovfNow  = isNum & postStat.expTooBig;

  always_comb begin
    unique case (rndMode)
      RND_NEAR: rndUp = preStat.guardBit &
                        (preStat.roundBit | preStat.stickyBit | preStat.lsbBit);
      RND_ZERO: rndUp = 1'b0;
      RND_DOWN: rndUp = inSign & lossAny;
      RND_UP:   rndUp = !inSign & lossAny;
      default:  rndUp = 1'b0;
    endcase
  end

  always_comb begin
    unique case (rndMode)
      RND_NEAR: toInf = 1'b1;
      RND_ZERO: toInf = 1'b0;
      RND_DOWN: toInf = inSign;
      RND_UP:   toInf = !inSign;
      default:  toInf = 1'b1;
    endcase
  end

  always_comb begin
    strb.load = inValid;
    unique case (inClass)
      CLS_ZERO: strb.sel = SEL_ZERO;
      CLS_INF:  strb.sel = SEL_INF;
      CLS_NAN:  strb.sel = SEL_NAN;
      default: begin
        if (preStat.subPath) begin
          strb.sel = postStat.minNorm ? SEL_MINNORM : SEL_SUB;
        end else if (postStat.expTooBig) begin
          strb.sel = toInf ? SEL_INF : SEL_MAXFIN;
        end else begin
          strb.sel = SEL_NORM;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      flagInexact   <= 1'b0;
      flagUnderflow <= 1'b0;
      flagOverflow  <= 1'b0;
      flagOpErr     <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        flagInexact   <= isNum & (lossAny | ovfNow);
        flagUnderflow <= isNum & preStat.subPath;
        flagOverflow  <= ovfNow;
        flagOpErr     <= ovfNow;
      end
    end
  end

  p_valid_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_ovf_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> flagInexact && flagOpErr && !flagUnderflow);

  p_inf_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inClass == CLS_INF |=> !flagInexact && !flagUnderflow && !flagOverflow);

  p_unf_num_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !isNum |=> !flagUnderflow && !flagOpErr);

endmodule

// File: rtl/sp_packer.sv
module sp_packer
  import sp_pack_pkg::*;
#(
  parameter int EXP_W  = 12,
  parameter int MANT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inClass,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [MANT_W-1:0] inMant,
  input  logic              inSticky,
  input  logic [1:0]        rndMode,
  output logic              outValid,
  output logic [31:0]       outWord,
  output logic              flagInexact,
  output logic              flagUnderflow,
  output logic              flagOverflow,
  output logic              flagOpErr
);

  valClass_e   clsE;
  rndMode_e    modeE;
  packStrobe_t strb;
  preStat_t    preStat;
  postStat_t   postStat;
  logic        rndUp;

  assign clsE  = valClass_e'(inClass);
  assign modeE = rndMode_e'(rndMode);

  sp_pack_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inClass      (clsE),
    .inSign       (inSign),
    .rndMode      (modeE),
    .preStat      (preStat),
    .postStat     (postStat),
    .rndUp        (rndUp),
    .strb         (strb),
    .outValid     (outValid),
    .flagInexact  (flagInexact),
    .flagUnderflow(flagUnderflow),
    .flagOverflow (flagOverflow),
    .flagOpErr    (flagOpErr)
  );

  sp_pack_dp #(
    .EXP_W (EXP_W),
    .MANT_W(MANT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rndUp   (rndUp),
    .inValid (inValid),
    .inClass (clsE),
    .inSign  (inSign),
    .inExp   ($signed(inExp)),
    .inMant  (inMant),
    .inSticky(inSticky),
    .preStat (preStat),
    .postStat(postStat),
    .outWord (outWord)
  );

endmodule

// File: tb/test_sp_packer.sv
module test_sp_packer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inClass = 2'd0;
  logic        inSign = 1'b0;
  logic [11:0] inExp = 12'd0;
  logic [31:0] inMant = 32'd0;
  logic        inSticky = 1'b0;
  logic [1:0]  rndMode = 2'd0;
  logic        outValid;
  logic [31:0] outWord;
  logic        flagInexact, flagUnderflow, flagOverflow, flagOpErr;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;
  bit    mdlValid = 1'b0;
  logic [35:0] mdlOut = '0;
  string lastTag = "R12";

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_packer i_sp_packer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass),
    .inSign(inSign), .inExp(inExp), .inMant(inMant), .inSticky(inSticky),
    .rndMode(rndMode), .outValid(outValid), .outWord(outWord),
    .flagInexact(flagInexact), .flagUnderflow(flagUnderflow),
    .flagOverflow(flagOverflow), .flagOpErr(flagOpErr)
  );

  // behavioural model: {inexact, underflow, overflow, operr, word}
  function automatic logic [35:0] refPack(input int cls, input bit sgn, input int ex,
                                          input longint unsigned mant, input bit stk,
                                          input int mode);
    int b, sh;
    longint unsigned q, rem, half;
    bit exact, up, toInf, unf;
    logic [31:0] w;
    if (cls == 0) return {4'b0000, sgn, 31'd0};
    if (cls == 2) return {4'b0000, sgn, 8'hFF, 23'd0};
    if (cls == 3) return {4'b0000, sgn, 8'hFF, 1'b1, mant[29:8]};
    b = ex + 127;
    sh = (b >= 1) ? 8 : 8 + (1 - b);
    if (sh > 40) sh = 40;
    q = mant >> sh;
    rem = mant - (q << sh);
    half = 64'd1 << (sh - 1);
    exact = (rem == 0) && !stk;
    case (mode)
      0: up = (rem > half) || ((rem == half) && (stk || q[0]));
      1: up = 0;
      2: up = sgn && !exact;
      default: up = !sgn && !exact;
    endcase
    q = q + (up ? 1 : 0);
    unf = (b < 1);
    if (unf) begin
      if (q == 64'd1 << 23) w = {sgn, 8'd1, 23'd0};
      else w = {sgn, 8'd0, q[22:0]};
      return {!exact, 1'b1, 2'b00, w};
    end
    if (q == 64'd1 << 24) begin
      b = b + 1;
      q = 64'd1 << 23;
    end
    if (b >= 255) begin
      toInf = (mode == 0) || (mode == 2 && sgn) || (mode == 3 && !sgn);
      w = toInf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
      return {4'b1011, w};
    end
    w = {sgn, b[7:0], q[22:0]};
    return {!exact, 3'b000, w};
  endfunction

  task automatic checkNow();
    logic [36:0] got, exp;
    got = {outValid, flagInexact, flagUnderflow, flagOverflow, flagOpErr, outWord};
    exp = {mdlValid, mdlOut};
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got v=%0b flags=%b word=%h, expected v=%0b flags=%b word=%h",
               lastTag, got[36], got[35:32], got[31:0], exp[36], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic drive(input int cls, input bit sgn, input int ex, input logic [31:0] mant,
                       input bit stk, input int mode, input bit vld, input string tag);
    @(negedge clk);
    checkNow();
    inValid  = vld;
    inClass  = cls[1:0];
    inSign   = sgn;
    inExp    = ex[11:0];
    inMant   = mant;
    inSticky = stk;
    rndMode  = mode[1:0];
    if (rstN) begin
      if (vld) mdlOut = refPack(cls, sgn, ex, {32'd0, mant}, stk, mode);
      mdlValid = vld;
    end
    lastTag = tag;
  endtask

  initial begin
    // reset: all outputs zero (R12)
    drive(1, 0, 0, 32'h80000000, 0, 0, 1, "R12");
    drive(0, 0, 0, 0, 0, 0, 0, "R12");
    drive(0, 0, 0, 0, 0, 0, 0, "R12");
    @(negedge clk);
    rstN = 1'b1;
    lastTag = "R12";

    drive(0, 0, 0, 0, 0, 0, 1, "R1");
    drive(0, 1, 5, 32'hFFFFFFFF, 1, 3, 1, "R1");
    drive(2, 0, 0, 0, 0, 0, 1, "R2");
    drive(2, 1, 0, 32'h12345678, 1, 1, 1, "R2");
    drive(3, 0, 0, 32'h80ABCD00, 0, 0, 1, "R3");
    drive(3, 1, 0, 32'hC0000100, 1, 2, 1, "R3");
    drive(1, 0, 0, 32'h80000000, 0, 0, 1, "R4");
    drive(1, 1, 10, 32'hA5A5A500, 0, 0, 1, "R4");
    drive(1, 0, 0, 32'h80000080, 0, 0, 1, "R4");
    drive(1, 0, 0, 32'h80000180, 0, 0, 1, "R4");
    drive(1, 0, 0, 32'h80000080, 1, 0, 1, "R5");
    drive(1, 0, 0, 32'h80000001, 0, 1, 1, "R5");
    drive(1, 0, 0, 32'h80000000, 1, 3, 1, "R5");
    for (int m = 0; m < 4; m++) begin
      drive(1, 0, 3, 32'h800000C0, 0, m, 1, "R4");
      drive(1, 1, 3, 32'h800000C0, 0, m, 1, "R4");
    end
    drive(1, 0, 0, 32'hFFFFFF80, 0, 0, 1, "R6");
    drive(1, 1, -20, 32'hFFFFFF01, 0, 2, 1, "R6");
    drive(1, 0, -127, 32'hC0000000, 0, 0, 1, "R7");
    drive(1, 1, -130, 32'hB3333333, 0, 0, 1, "R7");
    drive(1, 0, -149, 32'h80000000, 0, 0, 1, "R7");
    drive(1, 0, -150, 32'h80000000, 0, 0, 1, "R7");
    drive(1, 0, -150, 32'h80000001, 0, 0, 1, "R7");
    drive(1, 0, -127, 32'hFFFFFFFF, 0, 0, 1, "R8");
    drive(1, 1, -127, 32'hFFFFFF00, 0, 2, 1, "R8");
    drive(1, 0, -1000, 32'hFFFFFFFF, 1, 0, 1, "R9");
    drive(1, 0, -1000, 32'h80000000, 0, 3, 1, "R9");
    drive(1, 1, -200, 32'h80000000, 0, 2, 1, "R9");
    drive(1, 1, -176, 32'hFFFFFFFF, 1, 1, 1, "R9");
    drive(1, 0, 127, 32'hFFFFFF00, 0, 0, 1, "R10");
    drive(1, 0, 127, 32'hFFFFFF80, 0, 0, 1, "R10");
    for (int m = 0; m < 4; m++) begin
      drive(1, 0, 128, 32'h80000000, 0, m, 1, "R10");
      drive(1, 1, 2000, 32'h80000000, 0, m, 1, "R10");
    end
    drive(1, 0, 5, 32'h90000000, 0, 0, 1, "R11");
    drive(1, 1, 7, 32'h81000000, 1, 0, 0, "R11");
    drive(2, 0, 0, 0, 0, 0, 0, "R11");
    drive(1, 0, -140, 32'h80000000, 0, 0, 1, "R11");
    drive(0, 1, 0, 0, 0, 0, 0, "R11");

    for (int k = 0; k < 400; k++) begin
      int ex, cls;
      ex = int'($urandom % 330) - 170;
      cls = ($urandom % 8 == 0) ? int'($urandom % 4) : 1;
      drive(cls, $urandom % 2, ex, {1'b1, 31'($urandom)}, $urandom % 2,
            int'($urandom % 4), ($urandom % 5) != 0, "R4");
    end
    drive(0, 0, 0, 0, 0, 0, 0, "R11");
    drive(0, 0, 0, 0, 0, 0, 0, "R11");

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule